// File: doc/BRIEF.md
# Side-Set and Delay Field Sequencer

Each instruction in a small programmable I/O engine carries a five-bit field that is shared between two jobs: it can set a few output pins as a side effect of the instruction, and it can add idle cycles after the instruction completes. This block decodes that field and carries out both jobs. Two configuration inputs choose the split. One gives how many bits go to side-set, from 0 to 5. The other chooses whether side-set is optional. In optional mode the top bit acts as a per-instruction enable.

The execution unit presents an instruction on `issue_valid` with its field on `issue_field`. The block accepts the instruction only in a cycle where `busy` is low, so `busy` acts as the inverse of a ready signal. An issue offered while `busy` is high is dropped, and the issuer must hold or re-offer it until `busy` falls. The stall input `exec_stall` reports that the accepted instruction is blocked. Side-set is applied immediately, even if the instruction is stalled. The delay countdown starts only after the stall clears. While the block waits on a stall or counts delay cycles, `busy` stays high so that the program counter does not advance.

Top module: `sds_sequencer`

## Requirements
- R1: After reset, `side_pins` is 0, `side_update` is 0 and `busy` is 0.
- R2: In mandatory mode (`cfg_side_opt`=0) with count n from 0 to 5, bits [4:5-n] of the field are the side-set value and bits [4-n:0] are the delay. The value is driven right-aligned on `side_pins` and the upper pins are zero. With n=0 no side-set happens and all five bits are delay (0 to 31).
- R3: In optional mode (`cfg_side_opt`=1) with n from 1 to 4, bit 4 is the enable, bits [3:4-n] are the value and bits [3-n:0] are the delay. With n=0 the enable bit is not used and all five bits are delay.
- R4: When an accepted instruction has an enabled side-set, `side_update` pulses high and `side_pins` show the new value in the cycle after acceptance. This happens whether or not `exec_stall` is high in the acceptance cycle.
- R5: `side_pins` keep their last value when the enable bit is 0, when n is 0, and in every cycle without `side_update`.
- R6: If `exec_stall` is high in the acceptance cycle, the block waits until the first later cycle in which `exec_stall` is low, and only then counts the delay. If the stall lasts k cycles, counting from the acceptance cycle, and the delay is D, then `busy` is high for exactly k + D cycles starting the cycle after acceptance.
- R7: An instruction accepted with no stall and a delay of 0 leaves `busy` low in the next cycle, so instructions can be accepted back to back.
- R8: An issue offered while `busy` is high is ignored. It changes neither `side_pins` nor the length of the current busy period.
- R9: `cfg_err` is high when n > 4 in optional mode or n > 5 in mandatory mode. While it is high, accepted instructions apply no side-set and add no delay or stall hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_side_cnt | input | 3 | Number of side-set value bits (0 to 5 valid) |
| cfg_side_opt | input | 1 | 1 = side-set optional, with an enable bit at field bit 4 |
| issue_valid | input | 1 | An instruction is offered this cycle |
| issue_field | input | 5 | Side-set/delay field of the offered instruction |
| exec_stall | input | 1 | The accepted instruction is blocked this cycle |
| side_pins | output | 5 | Side-set pin values, held between updates |
| side_update | output | 1 | One-cycle pulse when new side-set values are applied |
| busy | output | 1 | Stall hold or delay in progress; no instruction accepted |
| cfg_err | output | 1 | Configuration is invalid |

## Verification
Applying a side-set and starting a stall hold can happen in the same cycle, and the side-set must win without waiting. The bench provokes this by accepting instructions with `exec_stall` held high for several cycles. In the first busy cycle, the model expects `side_update` high and the new pin value, and it then expects exactly k + D busy cycles. A second overlap is an issue that arrives while a delay is running. The bench keeps `issue_valid` asserted, with a different field, during busy cycles, and checks that neither the pins nor the busy length change.

// File: rtl/sds_pkg.sv
package sds_pkg;
  localparam int SDS_FIELD_W = 5;
  localparam int SDS_CNT_W   = $clog2(SDS_FIELD_W + 1);

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_HOLD  = 2'd1,
    SEQ_COUNT = 2'd2
  } seq_state_t;
endpackage

// File: rtl/sds_field_split.sv
module sds_field_split #(
  parameter int FIELD_W = sds_pkg::SDS_FIELD_W,
  parameter int CNT_W   = sds_pkg::SDS_CNT_W
) (
  input  logic [FIELD_W-1:0] field,
  input  logic [CNT_W-1:0]   side_cnt,
  input  logic               side_opt,
  output logic               side_en,
  output logic [FIELD_W-1:0] side_val,
  output logic [FIELD_W-1:0] delay,
  output logic               bad_cfg
);
  localparam int SW_W = CNT_W + 1;
  localparam logic [FIELD_W-1:0] ONES = {FIELD_W{1'b1}};

  logic            flag_used;
  logic [SW_W-1:0] side_w;
  logic [SW_W-1:0] shamt;

  always_comb begin
    bad_cfg   = side_opt ? (side_cnt > CNT_W'(FIELD_W - 1))
                         : (side_cnt > CNT_W'(FIELD_W));
    flag_used = side_opt && (side_cnt != '0);
    side_w    = {1'b0, side_cnt} + SW_W'(flag_used);
    shamt     = SW_W'(FIELD_W) - side_w;
    if (bad_cfg) begin
      side_en  = 1'b0;
      side_val = '0;
      delay    = '0;
    end else begin
      delay    = field & (ONES >> side_w);
      side_val = (field >> shamt) & ~(ONES << side_cnt);
      side_en  = (side_cnt != '0) && (!side_opt || field[FIELD_W-1]);
    end
  end

  // R3: in optional mode a cleared enable bit never yields a side-set
  always_comb begin
    if (side_opt && (side_cnt != '0) && !field[FIELD_W-1])
      assert_opt_flag_gates_R3: assert (!side_en);
  end
endmodule

// File: rtl/sds_delay_ctrl.sv
module sds_delay_ctrl #(
  parameter int FIELD_W = sds_pkg::SDS_FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue_valid,
  input  logic               stall,
  input  logic [FIELD_W-1:0] delay,
  output logic               accept,
  output logic               busy
);
  import sds_pkg::*;

  seq_state_t         state;
  logic [FIELD_W-1:0] cnt;

  assign busy   = (state != SEQ_IDLE);
  assign accept = issue_valid && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        SEQ_IDLE: begin
          if (accept) begin
            cnt <= delay;
            if (stall)             state <= SEQ_HOLD;
            else if (delay != '0)  state <= SEQ_COUNT;
          end
        end
        SEQ_HOLD: begin
          if (!stall) state <= (cnt != '0) ? SEQ_COUNT : SEQ_IDLE;
        end
        SEQ_COUNT: begin
          cnt <= cnt - 1'b1;
          if (cnt == FIELD_W'(1)) state <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // R6: pending delay is frozen while the stall persists
  assert_hold_freezes_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_HOLD && stall) |=> (state == SEQ_HOLD && $stable(cnt)));

  // R6: once counting, busy persists until the count is spent
  assert_count_keeps_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_COUNT && cnt > FIELD_W'(1)) |=> busy);
endmodule

// File: rtl/sds_pin_hold.sv
module sds_pin_hold #(
  parameter int FIELD_W = sds_pkg::SDS_FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FIELD_W-1:0] val,
  output logic [FIELD_W-1:0] pins,
  output logic               update
);
  for (genvar i = 0; i < FIELD_W; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (!rst_n)    pins[i] <= 1'b0;
      else if (load) pins[i] <= val[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) update <= 1'b0;
    else        update <= load;
  end
endmodule

// File: rtl/sds_sequencer.sv
module sds_sequencer #(
  parameter int FIELD_W = sds_pkg::SDS_FIELD_W,
  parameter int CNT_W   = sds_pkg::SDS_CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   cfg_side_cnt,
  input  logic               cfg_side_opt,
  input  logic               issue_valid,
  input  logic [FIELD_W-1:0] issue_field,
  input  logic               exec_stall,
  output logic [FIELD_W-1:0] side_pins,
  output logic               side_update,
  output logic               busy,
  output logic               cfg_err
);
  logic               sel_en;
  logic [FIELD_W-1:0] sel_val;
  logic [FIELD_W-1:0] sel_dly;
  logic               accept;

  sds_field_split #(.FIELD_W(FIELD_W), .CNT_W(CNT_W)) u_split (
    .field    (issue_field),
    .side_cnt (cfg_side_cnt),
    .side_opt (cfg_side_opt),
    .side_en  (sel_en),
    .side_val (sel_val),
    .delay    (sel_dly),
    .bad_cfg  (cfg_err)
  );

  sds_delay_ctrl #(.FIELD_W(FIELD_W)) u_delay (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid && !cfg_err),
    .stall       (exec_stall),
    .delay       (sel_dly),
    .accept      (accept),
    .busy        (busy)
  );

  sds_pin_hold #(.FIELD_W(FIELD_W)) u_pins (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept && sel_en),
    .val    (sel_val),
    .pins   (side_pins),
    .update (side_update)
  );

  // R4: side-set lands the cycle after acceptance, stall or not
  assert_side_immediate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !busy && !cfg_err && sel_en) |=> (side_update && side_pins == $past(sel_val)));

  // R5: pins move only with an update pulse
  assert_pins_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !side_update |-> $stable(side_pins));

  // R7: zero delay without stall costs no busy cycle
  assert_zero_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !busy && !exec_stall && sel_dly == '0) |=> !busy);

  // R8: no update while an instruction is still held
  assert_busy_blocks_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !side_update);

  // R9: invalid configuration leaves pins and busy untouched
  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !busy) |=> (!busy && !side_update));
endmodule

// File: tb/sds_sequencer_bench.sv
`timescale 1ns/1ps
module sds_sequencer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_side_cnt = 3'd0;
  logic       cfg_side_opt = 1'b0;
  logic       issue_valid = 1'b0;
  logic [4:0] issue_field = 5'd0;
  logic       exec_stall = 1'b0;
  logic [4:0] side_pins;
  logic       side_update;
  logic       busy;
  logic       cfg_err;

  always #2 clk = ~clk;

  sds_sequencer u_sds_sequencer (
    .clk(clk), .rst_n(rst_n), .cfg_side_cnt(cfg_side_cnt), .cfg_side_opt(cfg_side_opt),
    .issue_valid(issue_valid), .issue_field(issue_field), .exec_stall(exec_stall),
    .side_pins(side_pins), .side_update(side_update), .busy(busy), .cfg_err(cfg_err)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  int    cycles   = 0;
  bit    done     = 0;
  string cur_req  = "R1";

  // behavioural reference state
  bit m_hold = 0;
  int m_left = 0;
  int m_pend = 0;
  int m_pins = 0;
  bit m_upd  = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d @%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit mdl_err(int n, bit o);
    return o ? (n > 4) : (n > 5);
  endfunction

  function automatic void mdl_split(input int f, input int n, input bit o,
                                    output bit en, output int val, output int d);
    if (n == 0) begin en = 0; val = 0; d = f; end
    else if (!o) begin en = 1; val = f / (2 ** (5 - n)); d = f % (2 ** (5 - n)); end
    else begin en = (f >= 16); val = (f % 16) / (2 ** (4 - n)); d = f % (2 ** (4 - n)); end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hold = 0; m_left = 0; m_pend = 0; m_pins = 0; m_upd = 0;
    end else begin
      bit was_busy, en;
      int val, d;
      was_busy = m_hold || (m_left > 0);
      m_upd = 0;
      if (m_hold) begin
        if (!exec_stall) begin m_hold = 0; m_left = m_pend; end
      end else if (m_left > 0) begin
        m_left--;
      end else if (issue_valid && !was_busy && !mdl_err(cfg_side_cnt, cfg_side_opt)) begin
        mdl_split(issue_field, cfg_side_cnt, cfg_side_opt, en, val, d);
        if (en) begin m_pins = val; m_upd = 1; end
        if (exec_stall) begin m_hold = 1; m_pend = d; end
        else m_left = d;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, "busy", busy, int'(m_hold || m_left > 0));
      chk(cur_req, "side_pins", side_pins, m_pins);
      chk(cur_req, "side_update", side_update, m_upd);
      chk(cur_req, "cfg_err", cfg_err, mdl_err(cfg_side_cnt, cfg_side_opt));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 80; i++) begin
      if (!busy) break;
      tick();
    end
  endtask

  // offer one instruction; stall high for stall_cyc cycles from the issue cycle
  task automatic issue(input logic [4:0] f, input int stall_cyc);
    issue_valid = 1; issue_field = f; exec_stall = (stall_cyc > 0);
    tick();
    issue_valid = 0;
    for (int i = 1; i < stall_cyc; i++) tick();
    exec_stall = 0;
    wait_idle();
  endtask

  // count busy cycles after an issue; also samples first-cycle pins
  task automatic timed_issue(input logic [4:0] f, input int k, input string req,
                             input int exp_busy, input int exp_pins);
    int nb;
    issue_valid = 1; issue_field = f; exec_stall = (k > 0);
    tick();
    issue_valid = 0;
    chk(req, "side_pins first cycle", side_pins, exp_pins);
    chk(req, "side_update first cycle", side_update, 1);
    nb = 0;
    for (int i = 0; i < 60; i++) begin
      if (i >= k - 1) exec_stall = 0;
      if (!busy) break;
      nb++;
      tick();
    end
    chk(req, "busy length", nb, exp_busy);
  endtask

  logic [4:0] pats [5] = '{5'b10110, 5'b01011, 5'b11111, 5'b00000, 5'b10001};

  initial begin
    repeat (3) tick();
    // R1: reset values
    chk("R1", "side_pins reset", side_pins, 0);
    chk("R1", "side_update reset", side_update, 0);
    chk("R1", "busy reset", busy, 0);
    rst_n = 1;
    tick();

    // R2: mandatory split over every count
    cur_req = "R2";
    cfg_side_opt = 0;
    for (int n = 0; n <= 5; n++) begin
      cfg_side_cnt = 3'(n);
      foreach (pats[p]) issue(pats[p], 0);
    end

    // R3: optional split over every count
    cur_req = "R3";
    cfg_side_opt = 1;
    for (int n = 0; n <= 4; n++) begin
      cfg_side_cnt = 3'(n);
      foreach (pats[p]) issue(pats[p], 0);
    end

    // R5: disabled optional side-set keeps pins (opt, n=2, value 3 then enable low)
    cur_req = "R5";
    cfg_side_cnt = 3'd2;
    issue(5'b1_11_00, 0);
    issue(5'b0_01_00, 0);
    chk("R5", "pins after disabled side-set", side_pins, 3);

    // R4 + R6: side-set during stall, delay after stall (mandatory n=1, val 1, D=3)
    cur_req = "R6";
    cfg_side_opt = 0; cfg_side_cnt = 3'd1;
    timed_issue(5'b1_0011, 4, "R6", 7, 1);
    timed_issue(5'b0_0010, 6, "R4", 8, 0);
    timed_issue(5'b1_0101, 0, "R6", 5, 1);
    // stall with zero delay (n=2, val 2)
    cfg_side_cnt = 3'd2;
    timed_issue(5'b10_000, 3, "R6", 3, 2);

    // R7: zero delay back to back (n=5)
    cur_req = "R7";
    cfg_side_cnt = 3'd5;
    issue_valid = 1; issue_field = 5'b10101;
    tick();
    chk("R7", "busy after zero delay", busy, 0);
    chk("R7", "pins first", side_pins, 21);
    issue_field = 5'b01010;
    tick();
    issue_valid = 0;
    chk("R7", "pins second", side_pins, 10);
    chk("R7", "busy still low", busy, 0);
    tick();

    // R8: issue while busy is ignored (n=2, val 2, D=7)
    cur_req = "R8";
    cfg_side_cnt = 3'd2;
    issue_valid = 1; issue_field = 5'b10_111;
    tick();
    issue_field = 5'b01_000;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R8", "pins during busy", side_pins, 2);
    end
    issue_valid = 0;
    wait_idle();
    chk("R8", "pins after busy", side_pins, 2);

    // R9: invalid configurations
    cur_req = "R9";
    cfg_side_opt = 1; cfg_side_cnt = 3'd5;
    tick();
    chk("R9", "cfg_err opt n=5", cfg_err, 1);
    issue_valid = 1; issue_field = 5'b11111; exec_stall = 1;
    tick();
    issue_valid = 0; exec_stall = 0;
    chk("R9", "busy under error", busy, 0);
    chk("R9", "pins under error", side_pins, 2);
    cfg_side_opt = 0;
    for (int n = 6; n <= 7; n++) begin
      cfg_side_cnt = 3'(n);
      tick();
      chk("R9", "cfg_err mandatory", cfg_err, 1);
      issue(5'b11011, 0);
    end
    cfg_side_cnt = 3'd4;
    tick();
    chk("R9", "cfg_err cleared", cfg_err, 0);

    repeat (3) tick();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule